// File: doc/BRIEF.md
# Triple Match-Compare Timer

This block holds three independent 32-bit timers behind a simple register bus. Each timer has a counter that software can write, a reload value and two compare values. The timer can advance on every bus clock cycle, or once per rising edge of an external tick input. That input is brought into the clock domain through a two-flop synchronizer and then an edge detector. A single direction bit, shared by all three timers, selects counting down or counting up.

Counting down, a timer that steps from zero loads its reload value. This gives periodic operation. Counting up, a timer wraps from all-ones to zero. Either wrap raises an overflow event, but only if that timer's overflow interrupt enable is set. A timer raises a compare event on every counting step that lands on one of its two compare values. All events are collected in a sticky status register that is cleared by writing 1s. A mask register selects which status bits drive the single interrupt line.

Top module: `tri_match_timer`

## Requirements
- R1: Timer i (i = 0, 1, 2) has its register bank at byte offset 16*i: counter at +0x0, reload at +0x4, compare A at +0x8, compare B at +0xC. The control word is at 0x30, status at 0x34 and mask at 0x38. Reads of other offsets return 0. Control keeps bits [9:0], and status and mask keep bits [8:0]; the bits above those read 0. After reset every register reads 0, except the reload registers, which read 0xFFFFFFFF.
- R2: Control bit 3i enables timer i. When control bit 9 is 0 the timer counts down by one per step. A step taken from 0 loads the reload value and raises the timer's overflow event.
- R3: When control bit 9 is 1, enabled timers count up by one per step. A step taken from 0xFFFFFFFF gives 0 and raises the overflow event.
- R4: A timer whose enable bit is clear holds its count. This holds while the other timers count.
- R5: A counting step whose new count equals compare A sets status bit 3i. A step whose new count equals compare B sets status bit 3i+1. A compare 4 counts away from the start value is detected on the 4th step.
- R6: Status bit 3i+2 (overflow) is set only when control bit 3i+2 is 1.
- R7: Status bits stay set until they are cleared by writing a 1 to them at 0x34. An event in the same cycle as the clear wins, and the bit stays set.
- R8: The interrupt output is high exactly when some status bit is 1 and its mask bit is 0.
- R9: When control bit 3i+1 is 1, timer i steps once per rising edge of ext_tick, after the synchronizer. A high level that is held adds no further steps. With that bit at 0, the timer steps on every clock.
- R10: A bus write to a counter takes priority over a counting step in the same cycle, and that write raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| ext_tick | input | 1 | Asynchronous external tick |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: three timers, each 32 bits wide. At that width a natural wrap would take billions of cycles. Because the counters can be written, the bench preloads them near 0 or near 0xFFFFFFFF, which puts the reload and wrap edges, and the exact cycles of compare hits, within a few clocks. Three timers also allow one to count while another is held, and a third to run from the external tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  // register select within a bank (address bits [3:2])
  localparam logic [1:0] SEL_CNT    = 2'd0;
  localparam logic [1:0] SEL_RELOAD = 2'd1;
  localparam logic [1:0] SEL_CMPA   = 2'd2;
  localparam logic [1:0] SEL_CMPB   = 2'd3;
  // shared registers live in bank 3
  localparam logic [1:0] BANK_SHARED = 2'd3;
  localparam logic [1:0] SEL_CTRL    = 2'd0;
  localparam logic [1:0] SEL_STS     = 2'd1;
  localparam logic [1:0] SEL_MASK    = 2'd2;
  // per-timer field width in control and status
  localparam int FIELD_W = 3;
endpackage

// File: rtl/tmr_tick_sync.sv
module tmr_tick_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_async,
  output logic tick_rise
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tick_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign tick_rise = s2_q & ~s3_q;
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         up,
  input  logic         tick,
  input  logic [3:0]   wr,      // [0] count [1] reload [2] cmp A [3] cmp B
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reload_q,
  output logic [W-1:0] cmpa_q,
  output logic [W-1:0] cmpb_q,
  output logic         adv,
  output logic         ev_cmpa,
  output logic         ev_cmpb,
  output logic         ev_wrap
);
  function automatic logic [W-1:0] step_val(input logic [W-1:0] c,
                                            input logic [W-1:0] r,
                                            input logic up_i);
    if (up_i)           return c + W'(1);
    else if (c == '0)   return r;
    else                return c - W'(1);
  endfunction

  function automatic logic at_wrap(input logic [W-1:0] c, input logic up_i);
    return up_i ? (&c) : (c == '0);
  endfunction

  logic [W-1:0] nxt;
  logic         step;

  assign adv  = en & tick;
  assign step = adv & ~wr[0];
  assign nxt  = step_val(cnt_q, reload_q, up);

  assign ev_wrap = step & at_wrap(cnt_q, up);
  assign ev_cmpa = step & (nxt == cmpa_q);
  assign ev_cmpb = step & (nxt == cmpb_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '1;
      cmpa_q   <= '0;
      cmpb_q   <= '0;
    end else begin
      if (wr[0])     cnt_q <= wdata;
      else if (step) cnt_q <= nxt;
      if (wr[1]) reload_q <= wdata;
      if (wr[2]) cmpa_q   <= wdata;
      if (wr[3]) cmpb_q   <= wdata;
    end
  end
endmodule

// File: rtl/tri_match_timer.sv
module tri_match_timer
  import tmr_pkg::*;
#(
  parameter int W       = 32,
  parameter int NUM_TMR = 3,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic              ext_tick,
  output logic              irq
);
  localparam int CW  = FIELD_W * NUM_TMR + 1;
  localparam int SW  = FIELD_W * NUM_TMR;
  localparam int DIR = FIELD_W * NUM_TMR;

  logic [CW-1:0] ctrl_q;
  logic [SW-1:0] sts_q, mask_q, sts_clr, evt_set;
  logic          ext_rise;
  logic          in_range, wr_hit, shared_wr;
  logic [1:0]    bank, sel;

  logic [NUM_TMR-1:0][W-1:0] cnt_q, reload_q, cmpa_q, cmpb_q;
  logic [NUM_TMR-1:0]        adv, cnt_wr, reload_wr;

  assign bank      = bus_addr[5:4];
  assign sel       = bus_addr[3:2];
  assign in_range  = (bus_addr[ADDR_W-1:6] == '0);
  assign wr_hit    = bus_valid & bus_write & in_range;
  assign shared_wr = wr_hit & (bank == BANK_SHARED);
  assign sts_clr   = (shared_wr && sel == SEL_STS) ? bus_wdata[SW-1:0] : '0;

  tmr_tick_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_async(ext_tick),
    .tick_rise (ext_rise)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    logic [3:0] wr_vec;
    logic       ev_a, ev_b, ev_w;

    assign wr_vec       = (wr_hit && bank == 2'(i)) ? 4'(4'b1 << sel) : 4'b0;
    assign cnt_wr[i]    = wr_vec[0];
    assign reload_wr[i] = wr_vec[1];

    tmr_channel #(.W(W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (ctrl_q[FIELD_W*i]),
      .up      (ctrl_q[DIR]),
      .tick    (ctrl_q[FIELD_W*i+1] ? ext_rise : 1'b1),
      .wr      (wr_vec),
      .wdata   (bus_wdata),
      .cnt_q   (cnt_q[i]),
      .reload_q(reload_q[i]),
      .cmpa_q  (cmpa_q[i]),
      .cmpb_q  (cmpb_q[i]),
      .adv     (adv[i]),
      .ev_cmpa (ev_a),
      .ev_cmpb (ev_b),
      .ev_wrap (ev_w)
    );

    assign evt_set[FIELD_W*i +: FIELD_W] = {ev_w & ctrl_q[FIELD_W*i+2], ev_b, ev_a};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
      sts_q  <= '0;
    end else begin
      if (shared_wr && sel == SEL_CTRL) ctrl_q <= bus_wdata[CW-1:0];
      if (shared_wr && sel == SEL_MASK) mask_q <= bus_wdata[SW-1:0];
      sts_q <= (sts_q & ~sts_clr) | evt_set;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      if (bank == BANK_SHARED) begin
        case (sel)
          SEL_CTRL: bus_rdata = W'(ctrl_q);
          SEL_STS:  bus_rdata = W'(sts_q);
          SEL_MASK: bus_rdata = W'(mask_q);
          default:  bus_rdata = '0;
        endcase
      end else begin
        for (int i = 0; i < NUM_TMR; i++) begin
          if (bank == 2'(i)) begin
            case (sel)
              SEL_CNT:    bus_rdata = cnt_q[i];
              SEL_RELOAD: bus_rdata = reload_q[i];
              SEL_CMPA:   bus_rdata = cmpa_q[i];
              default:    bus_rdata = cmpb_q[i];
            endcase
          end
        end
      end
    end
  end

  assign irq = |(sts_q & ~mask_q);
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W       = 32,
  parameter int NUM_TMR = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [3*NUM_TMR:0]         ctrl_q,
  input logic [3*NUM_TMR-1:0]       sts_q,
  input logic [3*NUM_TMR-1:0]       sts_clr,
  input logic [3*NUM_TMR-1:0]       evt_set,
  input logic [NUM_TMR-1:0][W-1:0]  cnt_q,
  input logic [NUM_TMR-1:0][W-1:0]  reload_q,
  input logic [NUM_TMR-1:0][W-1:0]  cmpa_q,
  input logic [NUM_TMR-1:0]         adv,
  input logic [NUM_TMR-1:0]         cnt_wr,
  input logic [NUM_TMR-1:0]         reload_wr
);
  localparam int DIR = 3 * NUM_TMR;

  // R7
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_clr == '0) |=> (($past(sts_q) & ~sts_q) == '0));

  // R7
  sts_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_clr & ~evt_set) != '0) |=> ((sts_q & $past(sts_clr & ~evt_set)) == '0));

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
    // R4
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[3*i] && !cnt_wr[i]) |=> $stable(cnt_q[i]));

    // R2
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv[i] && !cnt_wr[i] && !reload_wr[i] && !ctrl_q[DIR] && cnt_q[i] == '0)
        |=> (cnt_q[i] == $past(reload_q[i])));

    // R6
    ovf_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts_q[3*i+2]) |-> $past(ctrl_q[3*i+2]));

    // R5
    cmpa_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(adv[i]) && !$past(cnt_wr[i]) && $stable(cmpa_q[i]) && cnt_q[i] == cmpa_q[i])
        |-> sts_q[3*i]);
  end
endmodule

bind tri_match_timer tmr_chk #(.W(W), .NUM_TMR(NUM_TMR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctrl_q   (ctrl_q),
  .sts_q    (sts_q),
  .sts_clr  (sts_clr),
  .evt_set  (evt_set),
  .cnt_q    (cnt_q),
  .reload_q (reload_q),
  .cmpa_q   (cmpa_q),
  .adv      (adv),
  .cnt_wr   (cnt_wr),
  .reload_wr(reload_wr)
);

// File: tb/tri_match_timer_tb.sv
module tri_match_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        ext_tick = 1'b0;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  tri_match_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_tick(ext_tick), .irq(irq)
  );

  // write/readback vectors: address, write data, expected readback (R1)
  localparam int NV = 8;
  localparam logic [7:0]  V_ADDR [NV] = '{8'h04, 8'h18, 8'h2C, 8'h38,
                                          8'h30, 8'h20, 8'h34, 8'h3C};
  localparam logic [31:0] V_WDAT [NV] = '{32'h12345678, 32'hCAFEF00D, 32'h0000FFFF, 32'hFFFFFFFF,
                                          32'hFFFFFC00, 32'hDEADBEEF, 32'hFFFFFFFF, 32'h00000005};
  localparam logic [31:0] V_EXP  [NV] = '{32'h12345678, 32'hCAFEF00D, 32'h0000FFFF, 32'h000001FF,
                                          32'h00000000, 32'hDEADBEEF, 32'h00000000, 32'h00000000};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called just after a falling edge; consumes exactly one rising edge
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset values
    rd(8'h04, v); chk("R1 reload reset", v, 32'hFFFFFFFF);
    rd(8'h24, v); chk("R1 reload3 reset", v, 32'hFFFFFFFF);
    rd(8'h00, v); chk("R1 count reset", v, 32'h0);
    rd(8'h30, v); chk("R1 ctrl reset", v, 32'h0);
    rd(8'h34, v); chk("R1 status reset", v, 32'h0);
    chk("R8 irq reset", {31'b0, irq}, 32'h0);

    // R1 table walk
    for (int k = 0; k < NV; k++) begin
      wr(V_ADDR[k], V_WDAT[k]);
      rd(V_ADDR[k], v);
      chk("R1 readback", v, V_EXP[k]);
    end

    // R2 down count and reload, R5 compares at 0, overflow enabled
    do_reset();
    wr(8'h00, 32'd5);
    wr(8'h04, 32'd9);
    wr(8'h30, 32'h5);
    repeat (5) @(negedge clk);
    rd(8'h00, v); chk("R2 count reached 0", v, 32'd0);
    rd(8'h34, v); chk("R5 both compares at 0", v, 32'h3);
    @(negedge clk);
    rd(8'h00, v); chk("R2 reload", v, 32'd9);
    rd(8'h34, v); chk("R2 overflow status", v, 32'h7);
    chk("R8 irq set", {31'b0, irq}, 32'h1);

    // R4 hold when disabled
    wr(8'h30, 32'h0);
    rd(8'h00, v); chk("R4 count at disable", v, 32'd8);
    repeat (4) @(negedge clk);
    rd(8'h00, v); chk("R4 held", v, 32'd8);

    // R7 clear one bit, R8 mask
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R7 w1c", v, 32'h6);
    wr(8'h38, 32'h6);
    chk("R8 all masked", {31'b0, irq}, 32'h0);
    wr(8'h38, 32'h2);
    chk("R8 overflow unmasked", {31'b0, irq}, 32'h1);

    // R6 overflow without enable
    wr(8'h34, 32'h1FF);
    wr(8'h08, 32'h100);
    wr(8'h0C, 32'h100);
    wr(8'h04, 32'd20);
    wr(8'h00, 32'd1);
    wr(8'h30, 32'h1);
    repeat (2) @(negedge clk);
    rd(8'h00, v); chk("R6 reloaded", v, 32'd20);
    rd(8'h34, v); chk("R6 no overflow bit", v, 32'h0);

    // R5 compare four counts away
    wr(8'h30, 32'h0);
    wr(8'h00, 32'd100);
    wr(8'h0C, 32'd96);
    wr(8'h30, 32'h1);
    repeat (3) @(negedge clk);
    rd(8'h34, v); chk("R5 not yet", v, 32'h0);
    @(negedge clk);
    rd(8'h00, v); chk("R5 count at compare", v, 32'd96);
    rd(8'h34, v); chk("R5 compare B hit", v, 32'h2);

    // R7 event wins over clear in the same cycle
    wr(8'h30, 32'h0);
    wr(8'h34, 32'h1FF);
    wr(8'h08, 32'h0);
    wr(8'h00, 32'd2);
    wr(8'h30, 32'h1);
    @(negedge clk);
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R7 event beats clear", v, 32'h1);
    wr(8'h34, 32'h1);
    rd(8'h34, v); chk("R7 later clear", v, 32'h0);

    // R3 up count wrap, R10 write priority, R4 independence
    do_reset();
    wr(8'h20, 32'd50);
    wr(8'h30, 32'h228);
    wr(8'h10, 32'hFFFFFFFE);
    rd(8'h10, v); chk("R10 write wins", v, 32'hFFFFFFFE);
    @(negedge clk);
    rd(8'h10, v); chk("R3 up step", v, 32'hFFFFFFFF);
    @(negedge clk);
    rd(8'h10, v); chk("R3 wrap to 0", v, 32'h0);
    rd(8'h34, v); chk("R3 overflow and compares", v, 32'h38);
    rd(8'h20, v); chk("R4 timer3 held", v, 32'd50);
    rd(8'h00, v); chk("R4 timer1 held", v, 32'd0);

    // R9 external tick on timer3, counting down
    wr(8'h30, 32'h0E8);
    wr(8'h20, 32'd10);
    repeat (4) @(negedge clk);
    rd(8'h20, v); chk("R9 no tick no step", v, 32'd10);
    ext_tick = 1'b1;
    repeat (6) @(negedge clk);
    rd(8'h20, v); chk("R9 one step for held level", v, 32'd9);
    ext_tick = 1'b0;
    repeat (4) @(negedge clk);
    ext_tick = 1'b1;
    repeat (2) @(negedge clk);
    ext_tick = 1'b0;
    repeat (4) @(negedge clk);
    rd(8'h20, v); chk("R9 second edge", v, 32'd8);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule